// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit turns the operand bytes of an 8-bit processor instruction into a 16-bit effective address. It also reports how many extra cycles the access costs. The caller presents the mode code, the low and high operand bytes, the two index registers, the address of the operand byte, an eligibility flag for the page-cross penalty and a branch-taken flag, and pulses `start`. Modes that need a pointer fetch it through a byte-wide read port. Read data returns one cycle after a read request.

When the result is ready, `done` pulses for one cycle. `ea` and `extra` hold their values until the next accepted request. Zero-page arithmetic and pointer reads reproduce the 8-bit wrap behaviour of the processor. The penalty count charges a cycle for each 256-byte page crossing the rules call for.

Top module: `idx_ea_gen`

## Requirements
- R1: While reset is active and after its release, `done`, `rd_en`, `ea` and `extra` are all zero.
- R2: Mode codes are fixed as follows: 0 zero page, 1 zero page plus X, 2 zero page plus Y, 3 absolute, 4 absolute plus X, 5 absolute plus Y, 6 pre-indexed pointer, 7 post-indexed pointer, 8 indirect jump, 9 relative branch. Codes 10 to 15 yield `ea` 0 and `extra` 0.
- R3: Modes 1 and 2 add the index to the low operand byte modulo 256. The address therefore always has a high byte of 0.
- R4: Mode 3 gives {hi,lo}. Modes 4 and 5 add X or Y to {hi,lo} modulo 65536.
- R5: In modes 4, 5 and 7, `extra` is 1 when the indexed address and its base differ in the high byte and the penalty flag is set. Otherwise `extra` is 0.
- R6: Mode 6 reads the pointer low byte at zero-page address (lo+X) mod 256 and the high byte at (lo+X+1) mod 256. The result is that pointer.
- R7: Mode 7 reads the pointer from zero-page addresses lo and (lo+1) mod 256, then adds Y modulo 65536.
- R8: Mode 8 reads the pointer low byte at {hi,lo} and the high byte at {hi,(lo+1) mod 256}. The high byte of the address is never incremented.
- R9: Mode 9 takes base = operand address + 1. When taken, `ea` = base + sign-extended lo (mod 65536) and `extra` = 1, or 2 if `ea` and base differ in the high byte. When not taken, `ea` = base and `extra` = 0.
- R10: `done` is high for exactly one cycle. It rises one clock after the accepting edge for modes without a pointer, and four clocks after it for modes 6, 7 and 8.
- R11: `start` is ignored while a pointer fetch is in progress. The running request completes with its own result, and only one `done` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| pc_opnd | input | 16 | Address of the first operand byte |
| pen_ok | input | 1 | Instruction is eligible for the page-cross penalty |
| br_taken | input | 1 | Branch condition holds |
| rd_en | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| ea | output | 16 | Effective address |
| extra | output | 2 | Extra cycle count |
| done | output | 1 | Result valid pulse |

## Verification
The hardest cases to reach are pointer fetches whose low byte sits at offset 0xFF of a page, because the high byte must come from offset 0x00 of the same page. This matters both in page zero and in the indirect jump. Directed requests place the operand or the sum lo+X exactly there. The bench memory returns a different computed byte for every address, so a wrong high-byte address always changes the result. Penalty and branch cases are aimed at 0xFF/0x00 page boundaries in both directions. Random requests cover the remaining combinations, and a request issued during a fetch checks that busy requests are dropped.

// File: rtl/idx_ea_gen.sv
module idx_ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [15:0] pc_opnd,
  input  logic        pen_ok,
  input  logic        br_taken,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic [15:0] ea,
  output logic [1:0]  extra,
  output logic        done
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABX = 4'd4, M_ABY = 4'd5, M_PRE = 4'd6, M_POST = 4'd7,
                         M_IND = 4'd8, M_REL = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_PLO, S_PHI, S_PWT} st_t;
  st_t st;

  logic [3:0]  mode_q;
  logic [7:0]  lo_q, hi_q, x_q, y_q, ptr_lo;
  logic [15:0] pc_q, ptr_base;
  logic        pen_q, tk_q;

  function automatic logic [17:0] calc(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                                       input logic [15:0] pc, input logic pen, tk,
                                       input logic [15:0] ptr);
    logic [15:0] s, nb;
    logic [1:0]  ex;
    ex = 2'd0;
    s  = 16'h0000;
    nb = pc + 16'd1;
    case (m)
      M_ZP:   s = {8'h00, lo};
      M_ZPX:  s = {8'h00, 8'(lo + x)};
      M_ZPY:  s = {8'h00, 8'(lo + y)};
      M_ABS:  s = {hi, lo};
      M_ABX: begin
        s = {hi, lo} + {8'h00, x};
        ex = {1'b0, pen && (s[15:8] != hi)};
      end
      M_ABY: begin
        s = {hi, lo} + {8'h00, y};
        ex = {1'b0, pen && (s[15:8] != hi)};
      end
      M_PRE:  s = ptr;
      M_POST: begin
        s = ptr + {8'h00, y};
        ex = {1'b0, pen && (s[15:8] != ptr[15:8])};
      end
      M_IND:  s = ptr;
      M_REL: begin
        if (tk) begin
          s = nb + {{8{lo[7]}}, lo};
          ex = (s[15:8] != nb[15:8]) ? 2'd2 : 2'd1;
        end else begin
          s = nb;
        end
      end
      default: s = 16'h0000;
    endcase
    return {ex, s};
  endfunction

  wire needs_ptr = (mode == M_PRE) || (mode == M_POST) || (mode == M_IND);

  always_comb begin
    case (mode_q)
      M_PRE:   ptr_base = {8'h00, 8'(lo_q + x_q)};
      M_POST:  ptr_base = {8'h00, lo_q};
      default: ptr_base = {hi_q, lo_q};
    endcase
  end

  assign rd_en   = (st == S_PLO) || (st == S_PHI);
  assign rd_addr = (st == S_PHI) ? {ptr_base[15:8], 8'(ptr_base[7:0] + 8'd1)} : ptr_base;

  logic [17:0] res_now, res_ptr;
  assign res_now = calc(mode, opnd_lo, opnd_hi, idx_x, idx_y, pc_opnd, pen_ok, br_taken, 16'h0000);
  assign res_ptr = calc(mode_q, lo_q, hi_q, x_q, y_q, pc_q, pen_q, tk_q, {rd_data, ptr_lo});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= 4'd0; lo_q <= 8'd0; hi_q <= 8'd0; x_q <= 8'd0; y_q <= 8'd0;
      pc_q <= 16'd0; pen_q <= 1'b0; tk_q <= 1'b0; ptr_lo <= 8'd0;
      ea <= 16'd0; extra <= 2'd0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode; lo_q <= opnd_lo; hi_q <= opnd_hi; x_q <= idx_x; y_q <= idx_y;
          pc_q <= pc_opnd; pen_q <= pen_ok; tk_q <= br_taken;
          if (needs_ptr) st <= S_PLO;
          else begin
            {extra, ea} <= res_now;
            done <= 1'b1;
          end
        end
        S_PLO: st <= S_PHI;
        S_PHI: begin
          ptr_lo <= rd_data;
          st <= S_PWT;
        end
        S_PWT: begin
          {extra, ea} <= res_ptr;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_ZPX || mode_q == M_ZPY)) |-> ea[15:8] == 8'h00);
  // R8
  ptr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PHI) |-> rd_addr[15:8] == $past(rd_addr[15:8]));
  // R9
  two_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && extra == 2'd2) |-> mode_q == M_REL);
  // R5
  no_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pen_q && mode_q != M_REL) |-> extra == 2'd0);
  // R11
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PLO || st == S_PHI) |=> !done);
endmodule

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;
  logic clk = 0, rst_n = 0, start = 0, pen_ok = 0, br_taken = 0;
  logic [3:0] mode = 0;
  logic [7:0] opnd_lo = 0, opnd_hi = 0, idx_x = 0, idx_y = 0, rd_data = 0;
  logic [15:0] pc_opnd = 0;
  logic rd_en, done;
  logic [15:0] rd_addr, ea;
  logic [1:0] extra;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  idx_ea_gen dut_i (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc_opnd(pc_opnd), .pen_ok(pen_ok),
    .br_taken(br_taken), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ea(ea),
    .extra(extra), .done(done));

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memfn(rd_addr);

  function automatic logic [17:0] model(input int m, input int lo, hi, x, y, pc, input bit pen, tk);
    int a, b, p, q, e;
    e = 0; a = 0;
    case (m)
      0: a = lo;
      1: a = (lo + x) % 256;
      2: a = (lo + y) % 256;
      3: a = hi * 256 + lo;
      4, 5: begin
        b = hi * 256 + lo;
        a = (b + ((m == 4) ? x : y)) % 65536;
        if (pen && (a / 256) != hi) e = 1;
      end
      6: begin
        q = (lo + x) % 256;
        a = memfn(16'((q + 1) % 256)) * 256 + memfn(16'(q));
      end
      7: begin
        p = memfn(16'((lo + 1) % 256)) * 256 + memfn(16'(lo));
        a = (p + y) % 65536;
        if (pen && (a / 256) != (p / 256)) e = 1;
      end
      8: a = memfn(16'(hi * 256 + (lo + 1) % 256)) * 256 + memfn(16'(hi * 256 + lo));
      9: begin
        b = (pc + 1) % 65536;
        if (tk) begin
          a = (b + ((lo >= 128) ? lo - 256 : lo) + 65536) % 65536;
          e = ((a / 256) != (b / 256)) ? 2 : 1;
        end else a = b;
      end
      default: a = 0;
    endcase
    return {2'(e), 16'(a)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic run(input string rq, input int m, lo, hi, x, y, pc, input bit pen, tk);
    logic [17:0] e;
    int lat;
    @(negedge clk);
    mode = 4'(m); opnd_lo = 8'(lo); opnd_hi = 8'(hi); idx_x = 8'(x); idx_y = 8'(y);
    pc_opnd = 16'(pc); pen_ok = pen; br_taken = tk; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    e = model(m, lo, hi, x, y, pc, pen, tk);
    chk(rq, {16'h0, extra, ea}, {14'h0, e});
    // R10
    chk("R10", lat, (m >= 6 && m <= 8) ? 4 : 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1", {ea, extra, done, rd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {ea, extra, done, rd_en}, 0);
    run("R2", 0, 8'h44, 8'h99, 0, 0, 0, 1, 0);
    run("R3", 1, 8'hF0, 8'h12, 8'h20, 0, 0, 1, 0);
    run("R3", 2, 8'hFF, 8'h12, 0, 8'h01, 0, 1, 0);
    run("R4", 3, 8'h34, 8'h12, 0, 0, 0, 1, 0);
    run("R5", 4, 8'hF0, 8'hFF, 8'h20, 0, 0, 1, 0);
    run("R5", 5, 8'hF0, 8'h10, 0, 8'h20, 0, 0, 0);
    run("R4", 5, 8'h10, 8'h10, 0, 8'h20, 0, 1, 0);
    run("R6", 6, 8'hF0, 0, 8'h0F, 0, 0, 0, 0);
    run("R6", 6, 8'h80, 0, 8'h90, 0, 0, 0, 0);
    run("R7", 7, 8'hFF, 0, 0, 8'hF0, 0, 1, 0);
    run("R7", 7, 8'h20, 0, 0, 8'hF0, 0, 0, 0);
    run("R8", 8, 8'hFF, 8'h12, 0, 0, 0, 0, 0);
    run("R9", 9, 8'h80, 0, 0, 0, 16'h1005, 0, 1);
    run("R9", 9, 8'h7F, 0, 0, 0, 16'h10F0, 0, 1);
    run("R9", 9, 8'h05, 0, 0, 0, 16'h1010, 0, 1);
    run("R9", 9, 8'h80, 0, 0, 0, 16'hFFFF, 0, 0);
    run("R2", 12, 8'h55, 8'h66, 1, 1, 16'h1234, 1, 1);
    // R11: second request while busy is dropped
    begin
      int dn;
      logic [17:0] e;
      @(negedge clk);
      mode = 4'd8; opnd_lo = 8'h33; opnd_hi = 8'h44; start = 1;
      @(negedge clk);
      mode = 4'd3; opnd_lo = 8'h01; opnd_hi = 8'h02;
      dn = 0;
      for (int i = 0; i < 8; i++) begin
        if (done) begin
          dn++;
          e = model(8, 8'h33, 8'h44, 0, 0, 0, 0, 0);
          chk("R11", {16'h0, extra, ea}, {14'h0, e});
        end
        if (i == 1) start = 0;
        @(negedge clk);
      end
      chk("R11", dn, 1);
    end
    for (int k = 0; k < 400; k++)
      run("R2", $urandom % 16, $urandom % 256, $urandom % 256, $urandom % 256,
          $urandom % 256, $urandom % 65536, 1'($urandom), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule